// File: doc/BRIEF.md
# SPI Byte Memory With Companion Register Slave

This block is an SPI slave that makes one serial port look like two separate targets. One target is a byte-wide memory array with the usual read, write, write-enable and status commands. The other is a small companion register file, reached only through its own pair of opcodes. Writes land in the array as each byte arrives on the bus, so there is no busy time and nothing to poll.

A write-enable latch must be set before any write is accepted, and it clears itself once a write transaction ends. Two status bits fence off an upper part of the array against writes. A lockout input, driven by a system reset supervisor, makes the slave ignore new commands. A memory write that is already in its data phase keeps going until chip select rises.

All serial inputs are brought into the system clock through a short synchronizer and are then processed as edge events. The SPI clock therefore has to run well below the system clock: each SPI clock phase must last at least six system clocks.

Top module: `nvspi_companion`

## Requirements
- R1: SPI mode 0. Bits on the data input are taken MSB first on rising clock edges. Read data is driven MSB first and changes after falling edges, so the first data bit is present after the falling edge that ends the last command or address bit. The data output is 0 when the slave is deselected and in any phase that is not returning data.
- R2: Opcode 0x03 followed by two address bytes (high byte first) reads the memory. Only the low MEM_AW address bits are used; the upper bits are ignored.
- R3: Opcode 0x02 followed by two address bytes and data bytes writes the memory at bus speed. The data can be read back by the very next transaction.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcodes 0x02, 0x01 and 0x12 are ignored while the latch is clear. Once one of them has been accepted, the latch clears when chip select rises.
- R5: Opcode 0x05 returns the status byte {4'b0, protect[1:0], wel, 1'b0}, with the latch in bit 1 and the protect field in bits 3:2. Further read bytes repeat it.
- R6: Opcode 0x01 with one data byte loads bits 3:2 of that byte into the protect field. The other bits are discarded.
- R7: Protect field 00 protects nothing, 01 the top quarter of the array, 10 the top half, and 11 the whole array. Writes to a protected address are dropped, but the burst address still advances.
- R8: Memory bursts advance the address by one per byte and wrap from the last location to 0.
- R9: Opcode 0x13 (read) and opcode 0x12 (write), each followed by one address byte, access a 2^REG_AW entry register file that is separate from the memory. Only the low REG_AW address bits are used, and bursts wrap within the register file.
- R10: A transaction that starts while the lockout input is high is ignored completely: no latch change, no writes, and the data output stays 0.
- R11: If lockout rises during the data phase of a memory write, the write continues and every remaining byte is stored until chip select rises.
- R12: If lockout rises during any other phase, the transaction is abandoned: the data output drops to 0 and no later byte has any effect.
- R13: After reset the latch and the protect field are 0 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI serial clock (mode 0) |
| cs_n_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data into the slave |
| lock_i | input | 1 | Lockout from the reset supervisor, active high |
| miso_o | output | 1 | Serial data out of the slave, registered |

## Verification
The assertions assume that the serial clock phases are long compared with the system clock, and that chip select does not rise until several system clocks after the last serial clock edge. Under those conditions a registered write strobe can never overlap a chip-select release. The assertions also assume that lockout changes only while the serial clock is idle between bytes, so a stored strobe is never caught by a lockout that rises in the same cycle. The stimulus keeps 80 ns serial clock phases against a 10 ns system clock. It waits after each byte before it moves chip select or lockout, and it holds data stable around every rising serial clock edge.

// File: rtl/nvspi_pkg.sv
`timescale 1ns/1ps
package nvspi_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RGRD  = 8'h13;
  localparam logic [7:0] OP_RGWR  = 8'h12;

  typedef enum logic [3:0] {
    ST_CMD, ST_AHI, ST_ALO, ST_MRD, ST_MWR,
    ST_RADR, ST_RRD, ST_RWR, ST_SRD, ST_SWR, ST_IGN
  } eng_state_t;

  typedef enum logic [1:0] {SP_MEM, SP_REG, SP_STAT} space_t;
endpackage

// File: rtl/nvspi_front.sv
`timescale 1ns/1ps
module nvspi_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  input  logic lock_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_n_s,
  output logic mosi_s,
  output logic lock_s
);
  localparam int W = 4;
  // bit order: {lock, mosi, cs_n, sck}; cs_n idles high
  localparam logic [W-1:0] RST_VAL = 4'b0010;

  logic [W-1:0] raw;
  logic [W-1:0] pipe [STAGES];
  logic         sck_d;

  assign raw = {lock_i, mosi_i, cs_n_i, sck_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      sck_d <= 1'b0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_d <= pipe[STAGES-1][0];
    end
  end

  assign sck_rise = pipe[STAGES-1][0] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][0] & sck_d;
  assign cs_n_s   = pipe[STAGES-1][1];
  assign mosi_s   = pipe[STAGES-1][2];
  assign lock_s   = pipe[STAGES-1][3];
endmodule

// File: rtl/nvspi_byte_ram.sv
`timescale 1ns/1ps
module nvspi_byte_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // single port, read-first: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvspi_engine.sv
`timescale 1ns/1ps
module nvspi_engine
  import nvspi_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              lock_s,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        reg_rdata,
  output logic [MEM_AW-1:0] ptr,
  output logic              mem_we,
  output logic              reg_we,
  output logic [7:0]        wdata,
  output logic              miso,
  output logic              wel,
  output logic [1:0]        bp,
  output logic              wr_armed
);
  localparam logic [MEM_AW-1:0] REG_MASK = MEM_AW'((1 << REG_AW) - 1);

  eng_state_t  state;
  space_t      space;
  logic        rd_op;
  logic [6:0]  rx_sr;
  logic [2:0]  bitcnt;
  logic [7:0]  tx_sr;
  logic [7:0]  ahi;
  logic [1:0]  ld_q;
  logic        wadv_q;

  logic [7:0]        nb;
  logic              byte_done;
  logic              prot;
  logic [MEM_AW-1:0] ptr_inc;
  logic [7:0]        load_val;
  logic [7:0]        status;

  assign nb        = {rx_sr, mosi_s};
  assign byte_done = sck_rise && (bitcnt == 3'd7);
  assign status    = {4'b0000, bp, wel, 1'b0};

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &ptr[MEM_AW-1 -: 2];
      2'b10:   prot = ptr[MEM_AW-1];
      default: prot = 1'b1;
    endcase
  end

  always_comb begin
    if (space == SP_REG) ptr_inc = (ptr + 1'b1) & REG_MASK;
    else                 ptr_inc = ptr + 1'b1;
  end

  always_comb begin
    unique case (space)
      SP_MEM:  load_val = mem_rdata;
      SP_REG:  load_val = reg_rdata;
      default: load_val = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CMD;
      space    <= SP_MEM;
      rd_op    <= 1'b0;
      rx_sr    <= '0;
      bitcnt   <= '0;
      tx_sr    <= '0;
      ahi      <= '0;
      ld_q     <= '0;
      wadv_q   <= 1'b0;
      ptr      <= '0;
      mem_we   <= 1'b0;
      reg_we   <= 1'b0;
      wdata    <= '0;
      miso     <= 1'b0;
      wel      <= 1'b0;
      bp       <= 2'b00;
      wr_armed <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      reg_we <= 1'b0;
      wadv_q <= 1'b0;
      ld_q   <= {ld_q[0], 1'b0};
      if (ld_q[1]) begin
        tx_sr <= load_val;
        if (space != SP_STAT) ptr <= ptr_inc;
      end
      if (wadv_q) ptr <= ptr_inc;

      if (cs_n_s) begin
        state  <= ST_CMD;
        bitcnt <= '0;
        miso   <= 1'b0;
        ld_q   <= '0;
        if (wr_armed) begin
          wel      <= 1'b0;
          wr_armed <= 1'b0;
        end
      end else if (lock_s && state != ST_MWR) begin
        state <= ST_IGN;
        miso  <= 1'b0;
      end else begin
        if (sck_fall) begin
          if (state == ST_MRD || state == ST_RRD || state == ST_SRD) begin
            miso  <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
          end else begin
            miso <= 1'b0;
          end
        end
        if (sck_rise) begin
          rx_sr  <= nb[6:0];
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          unique case (state)
            ST_CMD: begin
              unique case (nb)
                OP_WREN: begin wel <= 1'b1; state <= ST_IGN; end
                OP_WRDI: begin wel <= 1'b0; state <= ST_IGN; end
                OP_RDSR: begin
                  space <= SP_STAT;
                  state <= ST_SRD;
                  ld_q  <= {ld_q[0], 1'b1};
                end
                OP_WRSR: begin
                  if (wel) begin wr_armed <= 1'b1; state <= ST_SWR; end
                  else state <= ST_IGN;
                end
                OP_READ: begin space <= SP_MEM; rd_op <= 1'b1; state <= ST_AHI; end
                OP_WRITE: begin
                  if (wel) begin
                    space <= SP_MEM; rd_op <= 1'b0; wr_armed <= 1'b1; state <= ST_AHI;
                  end else state <= ST_IGN;
                end
                OP_RGRD: begin space <= SP_REG; rd_op <= 1'b1; state <= ST_RADR; end
                OP_RGWR: begin
                  if (wel) begin
                    space <= SP_REG; rd_op <= 1'b0; wr_armed <= 1'b1; state <= ST_RADR;
                  end else state <= ST_IGN;
                end
                default: state <= ST_IGN;
              endcase
            end
            ST_AHI: begin
              ahi   <= nb;
              state <= ST_ALO;
            end
            ST_ALO: begin
              ptr <= MEM_AW'({ahi, nb});
              if (rd_op) begin
                state <= ST_MRD;
                ld_q  <= {ld_q[0], 1'b1};
              end else begin
                state <= ST_MWR;
              end
            end
            ST_RADR: begin
              ptr <= MEM_AW'(nb[REG_AW-1:0]);
              if (rd_op) begin
                state <= ST_RRD;
                ld_q  <= {ld_q[0], 1'b1};
              end else begin
                state <= ST_RWR;
              end
            end
            ST_MRD, ST_RRD, ST_SRD: ld_q <= {ld_q[0], 1'b1};
            ST_MWR: begin
              wdata  <= nb;
              mem_we <= ~prot;
              wadv_q <= 1'b1;
            end
            ST_RWR: begin
              wdata  <= nb;
              reg_we <= 1'b1;
              wadv_q <= 1'b1;
            end
            ST_SWR: begin
              bp    <= nb[3:2];
              state <= ST_IGN;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nvspi_companion.sv
`timescale 1ns/1ps
module nvspi_companion #(
  parameter int MEM_AW      = 11,
  parameter int REG_AW      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  input  logic lock_i,
  output logic miso_o
);
  logic              sck_rise, sck_fall, cs_n_s, mosi_s, lock_s;
  logic [MEM_AW-1:0] ptr;
  logic              mem_we, reg_we, wel, wr_armed;
  logic [1:0]        bp;
  logic [7:0]        wdata, mem_rdata, reg_rdata;

  nvspi_front #(.STAGES(SYNC_STAGES)) i_front (
    .clk(clk), .rst(rst), .sck_i(sck_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i),
    .lock_i(lock_i), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .lock_s(lock_s)
  );

  nvspi_engine #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) i_engine (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .lock_s(lock_s),
    .mem_rdata(mem_rdata), .reg_rdata(reg_rdata), .ptr(ptr),
    .mem_we(mem_we), .reg_we(reg_we), .wdata(wdata), .miso(miso_o),
    .wel(wel), .bp(bp), .wr_armed(wr_armed)
  );

  nvspi_byte_ram #(.AW(MEM_AW), .DW(8)) i_mem (
    .clk(clk), .addr(ptr), .we(mem_we), .wdata(wdata), .rdata(mem_rdata)
  );

  nvspi_byte_ram #(.AW(REG_AW), .DW(8)) i_regs (
    .clk(clk), .addr(ptr[REG_AW-1:0]), .we(reg_we), .wdata(wdata), .rdata(reg_rdata)
  );
endmodule

// File: rtl/nvspi_companion_chk.sv
`timescale 1ns/1ps
module nvspi_companion_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n_s,
  input logic       lock_s,
  input logic       miso_o,
  input logic       mem_we,
  input logic       reg_we,
  input logic       wel,
  input logic       wr_armed,
  input logic [1:0] bp
);
  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_o);

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n_s) && wr_armed) |=> !wel);

  // R4
  wr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || reg_we) |-> wel);

  // R7
  prot_all_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bp != 2'b11));

  // R9
  space_sep_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, reg_we}));

  // R12
  lock_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_s && $past(lock_s)) |-> !reg_we);
endmodule

bind nvspi_companion nvspi_companion_chk i_chk (
  .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .lock_s(lock_s), .miso_o(miso_o),
  .mem_we(mem_we), .reg_we(reg_we), .wel(wel), .wr_armed(wr_armed), .bp(bp)
);

// File: tb/test_nvspi_companion.sv
`timescale 1ns/1ps
module test_nvspi_companion;
  localparam int MEM_AW = 11;
  localparam int REG_AW = 5;
  localparam logic [15:0] MMASK = 16'((1 << MEM_AW) - 1);
  localparam logic [7:0]  RMASK = 8'((1 << REG_AW) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, lock = 1'b0;
  logic miso;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] ref_mem [1 << MEM_AW];
  logic [7:0] ref_reg [1 << REG_AW];
  logic       ref_wel = 1'b0;
  logic [1:0] ref_bp = 2'b00;

  always #5 clk = ~clk;

  nvspi_companion #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) i_nvspi_companion (
    .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .lock_i(lock), .miso_o(miso)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic is_prot(input logic [15:0] a);
    case (ref_bp)
      2'b00:   return 1'b0;
      2'b01:   return &a[MEM_AW-1 -: 2];
      2'b10:   return a[MEM_AW-1];
      default: return 1'b1;
    endcase
  endfunction

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #80;
      rx[i] = miso;
      sck = 1'b1;
      #80;
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    #160;
  endtask

  task automatic cs_hi();
    #80;
    cs_n = 1'b1;
    #240;
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); spi_byte(op, d); cs_hi();
    if (op == 8'h06) ref_wel = 1'b1;
    if (op == 8'h04) ref_wel = 1'b0;
  endtask

  task automatic rd_status(input string req);
    logic [7:0] d;
    cs_lo();
    spi_byte(8'h05, d);
    for (int i = 0; i < 2; i++) begin
      spi_byte(8'h00, d);
      check8(req, d, {4'b0000, ref_bp, ref_wel, 1'b0});
    end
    cs_hi();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); spi_byte(8'h01, d); spi_byte(v, d); cs_hi();
    if (ref_wel) begin ref_bp = v[3:2]; ref_wel = 1'b0; end
  endtask

  task automatic mem_wr(input logic [15:0] a, input int n, input logic [7:0] d0);
    logic [7:0] d;
    logic [15:0] p;
    cs_lo();
    spi_byte(8'h02, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
    for (int i = 0; i < n; i++) spi_byte(d0 + 8'(i), d);
    cs_hi();
    if (ref_wel) begin
      p = a & MMASK;
      for (int i = 0; i < n; i++) begin
        if (!is_prot(p)) ref_mem[p] = d0 + 8'(i);
        p = (p + 16'd1) & MMASK;
      end
      ref_wel = 1'b0;
    end
  endtask

  task automatic mem_rd_chk(input logic [15:0] a, input int n, input string req);
    logic [7:0] d;
    cs_lo();
    spi_byte(8'h03, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, d);
      check8(req, d, ref_mem[(a + 16'(i)) & MMASK]);
    end
    cs_hi();
  endtask

  task automatic reg_wr(input logic [7:0] a, input int n, input logic [7:0] d0);
    logic [7:0] d;
    logic [7:0] p;
    cs_lo();
    spi_byte(8'h12, d); spi_byte(a, d);
    for (int i = 0; i < n; i++) spi_byte(d0 + 8'(i), d);
    cs_hi();
    if (ref_wel) begin
      p = a & RMASK;
      for (int i = 0; i < n; i++) begin
        ref_reg[p] = d0 + 8'(i);
        p = (p + 8'd1) & RMASK;
      end
      ref_wel = 1'b0;
    end
  endtask

  task automatic reg_rd_chk(input logic [7:0] a, input int n, input string req);
    logic [7:0] d;
    cs_lo();
    spi_byte(8'h13, d); spi_byte(a, d);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, d);
      check8(req, d, ref_reg[(a + 8'(i)) & RMASK]);
    end
    cs_hi();
  endtask

  task automatic t_reset();
    check8("R13 miso after reset", {7'b0, miso}, 8'h00);
    rd_status("R13/R5 status after reset");
  endtask

  task automatic t_wel();
    mem_wr(16'h0010, 1, 8'hA5);
    mem_rd_chk(16'h0010, 1, "R4 write without latch");
    op1(8'h06);
    rd_status("R4/R5 latch set");
    op1(8'h04);
    rd_status("R4 latch cleared by 0x04");
    reg_wr(8'h03, 1, 8'h77);
    reg_rd_chk(8'h03, 1, "R4 register write without latch");
  endtask

  task automatic t_mem();
    op1(8'h06);
    mem_wr(16'h0100, 4, 8'h30);
    rd_status("R4 latch cleared after write");
    mem_rd_chk(16'h0100, 4, "R3/R1 burst write readback");
    mem_rd_chk(16'hF102, 2, "R2 upper address bits ignored");
    check8("R1 miso idle when deselected", {7'b0, miso}, 8'h00);
  endtask

  task automatic t_wrap();
    op1(8'h06);
    mem_wr(16'h07FE, 4, 8'hC0);
    mem_rd_chk(16'h07FD, 5, "R8 burst wrap to zero");
  endtask

  task automatic t_protect();
    op1(8'h06); wr_status(8'h04);
    rd_status("R6 protect field 01");
    op1(8'h06); mem_wr(16'h05FE, 4, 8'h50);
    mem_rd_chk(16'h05FE, 4, "R7 top quarter protected");
    op1(8'h06); wr_status(8'hF8);
    rd_status("R6 only bits 3:2 kept");
    op1(8'h06); mem_wr(16'h03FF, 2, 8'h60);
    mem_rd_chk(16'h03FF, 2, "R7 top half protected");
    op1(8'h06); wr_status(8'h0C);
    op1(8'h06); mem_wr(16'h0000, 1, 8'h99);
    mem_rd_chk(16'h0000, 1, "R7 whole array protected");
    op1(8'h06); wr_status(8'h00);
    rd_status("R6 protect cleared");
  endtask

  task automatic t_regs();
    op1(8'h06);
    reg_wr(8'h3E, 3, 8'hE0);
    reg_rd_chk(8'h1D, 4, "R9 register burst wrap and low bits");
    mem_rd_chk(16'h001E, 2, "R9 memory untouched by register write");
  endtask

  task automatic t_lock_idle();
    logic [7:0] d;
    lock = 1'b1; #200;
    cs_lo(); spi_byte(8'h06, d); cs_hi();
    cs_lo();
    spi_byte(8'h03, d); spi_byte(8'h01, d); spi_byte(8'h00, d);
    spi_byte(8'h00, d);
    check8("R10 read while locked", d, 8'h00);
    cs_hi();
    lock = 1'b0; #200;
    rd_status("R10 latch unchanged by locked command");
  endtask

  task automatic t_lock_write();
    logic [7:0] d;
    op1(8'h06);
    cs_lo();
    spi_byte(8'h02, d); spi_byte(8'h02, d); spi_byte(8'h00, d);
    spi_byte(8'hD1, d);
    lock = 1'b1; #200;
    spi_byte(8'hD2, d); spi_byte(8'hD3, d);
    cs_hi();
    lock = 1'b0; #200;
    ref_mem[16'h0200] = 8'hD1; ref_mem[16'h0201] = 8'hD2; ref_mem[16'h0202] = 8'hD3;
    ref_wel = 1'b0;
    mem_rd_chk(16'h0200, 3, "R11 write finishes under lockout");
    rd_status("R11 latch cleared after write");
  endtask

  task automatic t_lock_abort();
    logic [7:0] d;
    cs_lo();
    spi_byte(8'h03, d); spi_byte(8'h01, d); spi_byte(8'h00, d);
    spi_byte(8'h00, d);
    check8("R12 first byte before lockout", d, ref_mem[16'h0100]);
    lock = 1'b1; #200;
    spi_byte(8'h00, d);
    check8("R12 read abandoned", d, 8'h00);
    cs_hi();
    lock = 1'b0; #200;
    op1(8'h06);
    cs_lo();
    spi_byte(8'h12, d); spi_byte(8'h05, d); spi_byte(8'hAA, d);
    lock = 1'b1; #200;
    spi_byte(8'hBB, d);
    cs_hi();
    lock = 1'b0; #200;
    ref_reg[5] = 8'hAA;
    ref_wel = 1'b0;
    reg_rd_chk(8'h05, 2, "R12 register write abandoned");
  endtask

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) ref_mem[i] = 8'h00;
    for (int i = 0; i < (1 << REG_AW); i++) ref_reg[i] = 8'h00;
    repeat (5) @(posedge clk);
    #5;
    rst = 1'b0;
    #100;
    t_reset();
    t_wel();
    t_mem();
    t_wrap();
    t_protect();
    t_regs();
    t_lock_idle();
    t_lock_write();
    t_lock_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule